// File: doc/BRIEF.md
# Rounded Integer Square Root Unit

This unit takes an unsigned operand and returns its square root rounded to the nearest integer. It works through the operand two bits at a time, starting with the top pair, using a shift-and-subtract recurrence. Each step compares the running remainder, extended by the next bit pair, against the root found so far with binary 01 appended below it. If the comparison leaves a non-negative difference, the step emits a 1 and keeps the difference; otherwise it emits a 0 and keeps the extended remainder. The unit runs one more step than there are integer root bits, feeding a zero pair. That last bit is the half bit, and it is added to the truncated root. Because of this the result is one bit wider than half the operand width.

Operands arrive on a valid/ready stream and results leave on a second valid/ready stream (AXI4-Stream TVALID/TREADY/TDATA semantics). A compile-time mode selects the structure. The serial structure reuses one step circuit and holds one operand at a time. The pipelined structure has one registered step per iteration and accepts an operand every clock. When the result cannot leave, every stage freezes together. The reset is asynchronous and active low, and its release is synchronized inside the unit. The input width is meant to be one of 8, 16, 32, 48, 64 or 128 bits. The number of steps is always IN_W/2 + 1, whatever the operand value.

Top module: `rsqrt_unit`

## Requirements
- R1: For every accepted operand x, out_data equals floor(sqrt(x)), plus 1 when x - r*r > r (where r = floor(sqrt(x))); that is, the square root rounded to nearest.
- R2: The all-ones operand gives 2^(IN_W/2), so the result needs IN_W/2 + 1 bits and never exceeds 2^(IN_W/2).
- R3: An operand of zero gives a result of zero.
- R4: In pipelined mode, a lone operand's result is valid in the IN_W/2 + 1-th cycle after the acceptance edge. With out_ready held high, K back-to-back operands finish within K + IN_W/2 + 1 cycles, one result per cycle.
- R5: In serial mode, in_ready stays low from acceptance until the result is taken. in_ready may rise in the same cycle that out_valid and out_ready are both high. K operands with out_ready held high take K × (IN_W/2 + 1) cycles.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged.
- R7: In pipelined mode, in_ready is low exactly when out_valid is high and out_ready is low. During that stall no stage advances.
- R8: After reset, out_valid is low and in_ready is high.
- R9: Results leave in acceptance order. Each accepted operand yields exactly one result, with none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit can take an operand this cycle |
| in_data | input | IN_W | Unsigned operand |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | IN_W/2+1 | Rounded square root |

## Verification
The assertions assume the producer and consumer follow stream rules. They assume an offered operand is held until it is taken. They also assume out_ready may change freely but is sampled only at clock edges. The stimulus keeps in_valid and in_data unchanged until a handshake is seen. It randomizes out_ready every cycle to create stalls, and it drives all inputs half a cycle away from the active edge. Operands are random 16-bit words mixed with directed values: zero, all ones, exact squares, halfway neighbours and alternating bit patterns.

// File: rtl/rsqrt_pkg.sv
`timescale 1ns/1ps
package rsqrt_pkg;
  typedef enum logic {
    RSQ_SERIAL    = 1'b0,
    RSQ_PIPELINED = 1'b1
  } rsqrt_mode_e;

  // root width including the rounding/half bit
  function automatic int unsigned root_bits(int unsigned in_w);
    return in_w / 2 + 1;
  endfunction
endpackage

// File: rtl/rsqrt_step.sv
`timescale 1ns/1ps
module rsqrt_step #(
  parameter int unsigned IN_W = 32,
  localparam int unsigned HW = IN_W / 2,
  localparam int unsigned OW = HW + 1,
  localparam int unsigned RW = HW + 3
) (
  input  logic [RW-1:0] rem_i,
  input  logic [OW-1:0] root_i,
  input  logic [1:0]    pair_i,
  output logic [RW-1:0] rem_o,
  output logic [OW-1:0] root_o
);
  localparam int unsigned TW = RW + 2;

  logic [TW-1:0] trial, subtr, diff;
  logic          take;
  logic          step_unused;

  always_comb begin
    trial  = {rem_i, pair_i};
    subtr  = {{(TW-OW-2){1'b0}}, root_i, 2'b01};
    diff   = trial - subtr;
    take   = (trial >= subtr);
    root_o = {root_i[OW-2:0], take};
    rem_o  = take ? diff[RW-1:0] : trial[RW-1:0];
  end

  assign step_unused = ^{diff[TW-1:RW], trial[TW-1:RW], root_i[OW-1]};
endmodule

// File: rtl/rsqrt_serial.sv
`timescale 1ns/1ps
module rsqrt_serial #(
  parameter int unsigned IN_W = 32,
  localparam int unsigned HW = IN_W / 2,
  localparam int unsigned OW = HW + 1,
  localparam int unsigned RW = HW + 3,
  localparam int unsigned NI = HW + 1,
  localparam int unsigned CW = $clog2(NI + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [IN_W-1:0] in_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [OW-1:0]   root_o
);
  logic            busy_q, busy_d;
  logic            outv_q, outv_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [IN_W-1:0] data_q;
  logic [RW-1:0]   rem_q, s_rem, s_rem_nx;
  logic [OW-1:0]   root_q, s_root, s_root_nx;
  logic [1:0]      s_pair;
  logic            accept, step_en;

  assign in_ready  = !busy_q && (!outv_q || out_ready);
  assign accept    = in_valid && in_ready;
  assign step_en   = accept || busy_q;
  assign out_valid = outv_q;
  assign root_o    = root_q;

  // the first iteration runs on the acceptance edge itself
  always_comb begin
    s_rem  = accept ? '0 : rem_q;
    s_root = accept ? '0 : root_q;
    s_pair = accept ? in_data[IN_W-1 -: 2] : data_q[IN_W-1 -: 2];
  end

  rsqrt_step #(.IN_W(IN_W)) u_step (
    .rem_i (s_rem),
    .root_i(s_root),
    .pair_i(s_pair),
    .rem_o (s_rem_nx),
    .root_o(s_root_nx)
  );

  always_comb begin
    busy_d = busy_q;
    outv_d = outv_q;
    cnt_d  = cnt_q;
    if (accept) begin
      busy_d = 1'b1;
      outv_d = 1'b0;
      cnt_d  = CW'(1);
    end else if (busy_q) begin
      cnt_d = cnt_q + CW'(1);
      if (cnt_q == CW'(NI - 1)) begin
        busy_d = 1'b0;
        outv_d = 1'b1;
      end
    end else if (outv_q && out_ready) begin
      outv_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      outv_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      outv_q <= outv_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (step_en) begin
      data_q <= accept ? (in_data << 2) : (data_q << 2);
      rem_q  <= s_rem_nx;
      root_q <= s_root_nx;
    end
  end

  // R5: once an operand is taken the input side closes
  p_ready_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  // R5: a result is only raised after the full iteration count
  p_done_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(outv_q) |-> ($past(busy_q) && $past(cnt_q) == CW'(NI - 1)));
endmodule

// File: rtl/rsqrt_pipe.sv
`timescale 1ns/1ps
module rsqrt_pipe #(
  parameter int unsigned IN_W = 32,
  localparam int unsigned HW = IN_W / 2,
  localparam int unsigned OW = HW + 1,
  localparam int unsigned RW = HW + 3,
  localparam int unsigned NI = HW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [IN_W-1:0] in_data,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [OW-1:0]   root_o
);
  logic            vld_q  [NI];
  logic [RW-1:0]   rem_q  [NI];
  logic [OW-1:0]   root_q [NI];
  logic [IN_W-1:0] dat_q  [NI];
  logic            adv;
  logic            pipe_unused;

  assign adv       = !(vld_q[NI-1] && !out_ready);
  assign in_ready  = adv;
  assign out_valid = vld_q[NI-1];
  assign root_o    = root_q[NI-1];
  assign pipe_unused = ^{dat_q[NI-1], rem_q[NI-1]};

  for (genvar k = 0; k < NI; k++) begin : g_stage
    logic            v_in;
    logic [RW-1:0]   r_in, r_nx;
    logic [OW-1:0]   q_in, q_nx;
    logic [IN_W-1:0] d_in;

    if (k == 0) begin : g_head
      assign v_in = in_valid;
      assign r_in = '0;
      assign q_in = '0;
      assign d_in = in_data;
    end else begin : g_link
      assign v_in = vld_q[k-1];
      assign r_in = rem_q[k-1];
      assign q_in = root_q[k-1];
      assign d_in = dat_q[k-1];
    end

    rsqrt_step #(.IN_W(IN_W)) u_step (
      .rem_i (r_in),
      .root_i(q_in),
      .pair_i(d_in[IN_W-1 -: 2]),
      .rem_o (r_nx),
      .root_o(q_nx)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q[k] <= 1'b0;
      else if (adv) vld_q[k] <= v_in;
    end

    always_ff @(posedge clk) begin
      if (adv) begin
        rem_q[k]  <= r_nx;
        root_q[k] <= q_nx;
        dat_q[k]  <= d_in << 2;
      end
    end
  end

  // R7: a blocked output freezes the last stage
  p_stall_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q[NI-1] && !out_ready) |=> (vld_q[NI-1] && $stable(root_q[NI-1])));
  // R4: an accepted operand occupies the first stage next cycle
  p_enter_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> vld_q[0]);
endmodule

// File: rtl/rsqrt_round.sv
`timescale 1ns/1ps
module rsqrt_round #(
  parameter int unsigned OUT_W = 17
) (
  input  logic [OUT_W-1:0] root_i,
  output logic [OUT_W-1:0] rounded_o
);
  // bit 0 is the half bit from the extra iteration
  assign rounded_o = {1'b0, root_i[OUT_W-1:1]} + {{(OUT_W-1){1'b0}}, root_i[0]};
endmodule

// File: rtl/rsqrt_unit.sv
`timescale 1ns/1ps
module rsqrt_unit
  import rsqrt_pkg::*;
#(
  parameter rsqrt_mode_e MODE = RSQ_PIPELINED,
  parameter int unsigned IN_W = 32,
  localparam int unsigned OUT_W = root_bits(IN_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data
);
  localparam int unsigned HW = IN_W / 2;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [OUT_W-1:0] root_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  if (MODE == RSQ_SERIAL) begin : g_serial
    rsqrt_serial #(.IN_W(IN_W)) u_core (
      .clk(clk), .rst_n(rst_int_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .root_o(root_full)
    );
  end else begin : g_pipe
    rsqrt_pipe #(.IN_W(IN_W)) u_core (
      .clk(clk), .rst_n(rst_int_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .out_valid(out_valid), .out_ready(out_ready), .root_o(root_full)
    );
  end

  rsqrt_round #(.OUT_W(OUT_W)) u_round (
    .root_i   (root_full),
    .rounded_o(out_data)
  );

  // R6: an offered result is held until taken
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R2: rounded result never exceeds 2^(IN_W/2)
  p_range_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid |-> (out_data <= (OUT_W'(1) << HW)));
endmodule

// File: tb/test_rsqrt_unit.sv
`timescale 1ns/1ps
module test_rsqrt_unit;
  import rsqrt_pkg::*;

  localparam int unsigned IW = 16;
  localparam int unsigned HW = IW / 2;
  localparam int unsigned OW = HW + 1;
  localparam int unsigned NI = HW + 1;
  localparam int unsigned WD_LIMIT = 150000;

  logic clk, rst_n;
  // index 0: serial unit, index 1: pipelined unit
  logic          iv   [2];
  logic [IW-1:0] id   [2];
  logic          ir   [2];
  logic          ov   [2];
  logic          ordr [2];
  logic [OW-1:0] od   [2];

  int n_chk = 0, n_fail = 0;
  int unsigned cycles = 0;
  bit wd = 0;
  int unsigned q_in0[$], q_in1[$];

  rsqrt_unit #(.MODE(RSQ_PIPELINED), .IN_W(IW)) i_rsqrt_unit (
    .clk(clk), .rst_n(rst_n),
    .in_valid(iv[1]), .in_ready(ir[1]), .in_data(id[1]),
    .out_valid(ov[1]), .out_ready(ordr[1]), .out_data(od[1])
  );

  rsqrt_unit #(.MODE(RSQ_SERIAL), .IN_W(IW)) i_rsqrt_unit_serial (
    .clk(clk), .rst_n(rst_n),
    .in_valid(iv[0]), .in_ready(ir[0]), .in_data(id[0]),
    .out_valid(ov[0]), .out_ready(ordr[0]), .out_data(od[0])
  );

  // 50 MHz
  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WD_LIMIT) wd <= 1'b1;
  end

  function automatic int unsigned ref_root(int unsigned x);
    int unsigned r = 0;
    for (int b = HW - 1; b >= 0; b--) begin
      int unsigned t = r | (32'd1 << b);
      if (t * t <= x) r = t;
    end
    if (x - r * r > r) r = r + 1;
    return r;
  endfunction

  function automatic int unsigned corner(int i);
    case (i % 16)
      0: return 0;       1: return 1;       2: return 2;       3: return 3;
      4: return 65535;   5: return 65534;   6: return 65025;   7: return 65280;
      8: return 65281;   9: return 16'hAAAA; 10: return 16'h5555; 11: return 16'h3333;
      12: return 16'hCCCC; 13: return 16'h0F0F; 14: return 56;   default: return 57;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int unsigned act, int unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int qsize(int m);
    return (m == 0) ? q_in0.size() : q_in1.size();
  endfunction

  task automatic push_in(int m, int unsigned x);
    if (m == 0) q_in0.push_back(x); else q_in1.push_back(x);
  endtask

  // compare the result presented now against the oldest accepted operand
  task automatic pop_check(int m);
    int unsigned x, e;
    if (qsize(m) == 0) begin
      chk(1'b0, "R9 extra result", od[m], 0);
      return;
    end
    x = (m == 0) ? q_in0.pop_front() : q_in1.pop_front();
    e = ref_root(x);
    if (x == 0)          chk(od[m] == e, "R3 zero operand", od[m], e);
    else if (x == 65535) chk(od[m] == e, "R2 all-ones operand", od[m], e);
    else                 chk(od[m] == e, "R1 R9 rounded root in order", od[m], e);
  endtask

  task automatic stream(int m, int n, int vp, int rp, bit use_corner);
    int sent = 0;
    bit hold = 0;
    int bad5 = 0, bad7 = 0;
    while ((sent < n || qsize(m) > 0) && !wd) begin
      @(negedge clk);
      if (!hold) begin
        if (sent < n && ($urandom % 100) < vp) begin
          iv[m] = 1'b1;
          id[m] = use_corner ? IW'(corner(sent)) : IW'($urandom);
          hold  = 1;
        end else begin
          iv[m] = 1'b0;
        end
      end
      ordr[m] = (($urandom % 100) < rp);
      #1;
      if (m == 0 && qsize(m) > 0 && ir[m] && !(ov[m] && ordr[m])) bad5++;
      if (m == 1 && ir[m] != !(ov[m] && !ordr[m])) bad7++;
      if (ov[m] && ordr[m]) pop_check(m);
      if (iv[m] && ir[m]) begin
        push_in(m, id[m]);
        sent++;
        hold = 0;
      end
    end
    @(negedge clk);
    iv[m] = 1'b0;
    ordr[m] = 1'b1;
    if (m == 0) chk(bad5 == 0, "R5 serial in_ready low while busy", bad5, 0);
    else        chk(bad7 == 0, "R7 pipelined in_ready vs stall", bad7, 0);
  endtask

  // back-to-back operands with the output always ready; returns cycle of last result
  task automatic timed(int m, int k, int exp_last, string tag);
    int j = 0, last = -1, cyc = 0;
    bit hold = 0;
    ordr[m] = 1'b1;
    @(negedge clk);
    while ((j < k || qsize(m) > 0) && cyc < 2000 && !wd) begin
      if (!hold) begin
        if (j < k) begin
          iv[m] = 1'b1;
          id[m] = IW'($urandom);
          hold  = 1;
        end else begin
          iv[m] = 1'b0;
        end
      end
      #1;
      if (ov[m] && ordr[m]) begin
        pop_check(m);
        last = cyc;
      end
      if (iv[m] && ir[m]) begin
        push_in(m, id[m]);
        j++;
        hold = 0;
      end
      cyc++;
      @(negedge clk);
    end
    iv[m] = 1'b0;
    chk(last == exp_last, tag, last, exp_last);
  endtask

  // hold one result under backpressure and confirm it is stable and single
  task automatic backpressure(int m);
    ordr[m] = 1'b0;
    @(negedge clk);
    iv[m] = 1'b1;
    id[m] = 16'd57;
    #1;
    chk(ir[m] == 1'b1, "R8 idle unit accepts", ir[m], 1);
    @(negedge clk);
    iv[m] = 1'b0;
    repeat (NI + 3) @(negedge clk);
    #1;
    chk(ov[m] == 1'b1, "R6 result held under backpressure", ov[m], 1);
    chk(od[m] == 8, "R1 R6 held value for 57", od[m], 8);
    chk(ir[m] == 1'b0, (m == 0) ? "R5 serial input closed" : "R7 pipelined stall closes input", ir[m], 0);
    repeat (3) @(negedge clk);
    #1;
    chk(ov[m] == 1'b1 && od[m] == 8, "R6 result stable while blocked", od[m], 8);
    ordr[m] = 1'b1;
    @(negedge clk);
    #1;
    chk(ov[m] == 1'b0, "R9 result leaves exactly once", ov[m], 0);
  endtask

  initial begin
    process::self().srandom(32'd20240611);
    for (int m = 0; m < 2; m++) begin
      iv[m] = 1'b0; id[m] = '0; ordr[m] = 1'b1;
    end
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    for (int m = 0; m < 2; m++) begin
      chk(ov[m] == 1'b0, "R8 out_valid low after reset", ov[m], 0);
      chk(ir[m] == 1'b1, "R8 in_ready high after reset", ir[m], 1);
    end

    // R4 / R5 latency and throughput
    timed(1, 1, NI, "R4 pipelined single latency");
    timed(1, 20, NI + 20 - 1, "R4 pipelined one result per cycle");
    timed(0, 1, NI, "R5 serial single latency");
    timed(0, 6, 6 * NI, "R5 serial K operands in K*(IN_W/2+1)");

    backpressure(1);
    backpressure(0);

    // directed corners then constrained random with stalls
    for (int m = 0; m < 2; m++) begin
      stream(m, 16, 100, 100, 1'b1);
      stream(m, 16, 60, 40, 1'b1);
      stream(m, 200, 70, 60, 1'b0);
    end

    if (wd) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected below %0d", cycles, WD_LIMIT);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule